// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects 32 level-sensitive interrupt lines from peripherals and presents them to a processor as two request outputs: a normal request and a fast request. Each line has an enable bit and a steering bit that chooses which of the two outputs it drives. Software configures and inspects the controller through a small 32-bit register bus with address, write-enable, write data and registered read data. Clearing an interrupt is done at the peripheral that raised it, so the controller itself holds no sticky pending state. The raw lines are simply resynchronized and combined with the enable and steering masks.

A programmable priority table lets software decide which line is most urgent. Every table entry names one source and carries a valid flag. Each cycle the controller walks the table from entry 0 upward and picks the first valid entry whose source is pending, enabled and steered to the normal request. A readable "winner" register then reports that source number together with a valid flag, so the interrupt handler finds its source in one read instead of scanning a bit vector.

A separate wake output tells the power controller that the processor should leave idle. One control bit chooses whether every raw pending line can cause a wake, or only enabled ones.

Top module: `prio_intc`

## Requirements
- R1: Registers are 32-bit words at byte offsets: normal-pending 0x000, enable 0x004, steering 0x008, fast-pending 0x00C, raw-lines 0x010, control 0x014, winner 0x018, and table entry i at 0x01C + 4*i (i = 0..31). Read data appears on `bus_rdata` in the cycle after the address is presented. Addresses that are not word-aligned read as 0 and ignore writes.
- R2: Enable bit n = 1 lets source n through and 0 blocks it. All enable bits are 0 after reset, so every source starts blocked and neither request output is asserted.
- R3: Steering bit n = 0 sends source n to `irq_o` and 1 sends it to `fiq_o`. All steering bits are 0 after reset.
- R4: The normal-pending register reads raw AND enable AND NOT steering. `irq_o` is high exactly when that value is non-zero.
- R5: The fast-pending register reads raw AND enable AND steering. `fiq_o` is high exactly when that value is non-zero.
- R6: Each source passes through a two-flop synchronizer. The raw-lines register shows the synchronized line levels. `irq_o`, `fiq_o` and `wake_o` follow a change on `src_i` at the second rising clock edge after it, not at the first.
- R7: In table entry i, bit 31 is a valid flag and bits 4:0 name a source. All other bits are not stored and read as 0. Every entry reads 0 after reset.
- R8: Arbitration picks the lowest-index valid table entry whose named source is pending, enabled and steered to `irq_o`. An entry with a clear valid flag never wins, even when its source is the only pending one.
- R9: The winner register reads bit 31 = 1 and bits 30:16 = the winning source number when an entry wins. All other bits are 0, and the whole word is 0 when no entry wins.
- R10: Control bit 0 (reset value 0) selects the wake source. At 0, `wake_o` is high when any raw line is high. At 1, it is high only when some enabled raw line is high. The control register reads back bit 0 only.
- R11: Writes to the normal-pending, fast-pending, raw-lines and winner offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Asynchronous level-sensitive source lines |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write commits at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, for the address of the previous cycle |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle-wake request |

## Verification
Source changes reach `irq_o`, `fiq_o`, `wake_o` and the raw-lines register two rising edges after `src_i` moves. The bench therefore drives sources on a falling edge and samples after two more falling edges. It also samples once after a single edge, where the outputs must still show the old value. A register read returns data one edge after the address is driven, and a write takes effect at the edge that samples it. The bench therefore samples `bus_rdata` on the falling edge that follows each read address, and issues every check read only after the write it depends on has committed. The expected values for pending words, request outputs, wake and the winner are computed in the bench from its own copy of the enable, steering, control and table settings. These are checked across one-hot sweeps of all 32 sources and across pseudo-random mixtures.

// File: rtl/prio_intc_pkg.sv
// Shared constants for the prioritized interrupt controller.
// Word indices are byte offsets divided by four.
package prio_intc_pkg;
    localparam int DATA_W    = 32;
    localparam int W_IRQPEND = 0;
    localparam int W_ENABLE  = 1;
    localparam int W_STEER   = 2;
    localparam int W_FIQPEND = 3;
    localparam int W_RAW     = 4;
    localparam int W_CTRL    = 5;
    localparam int W_WINNER  = 6;
    localparam int W_TABLE0  = 7;
endpackage

// File: rtl/intc_sync.sv
// intc_sync: two-flop synchronizer for a vector of asynchronous level lines.
// Assumes each line is quasi-static relative to the clock (level sources);
// no bus coherency is guaranteed between bits.
module intc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the lines through two flops, clearing both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/intc_prio_bank.sv
// intc_prio_bank: storage for the priority table, one entry per level.
// Each entry holds a valid flag and a source number. The caller decodes the
// address and presents a single write per cycle.
module intc_prio_bank #(
    parameter int NUM_LVL = 32,
    parameter int SRC_W   = 5,
    localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [LVL_W-1:0]                wr_lvl,
    input  logic                            wr_valid,
    input  logic [SRC_W-1:0]                wr_src,
    output logic [NUM_LVL-1:0]              lvl_valid,
    output logic [NUM_LVL-1:0][SRC_W-1:0]   lvl_src
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_entry
        // Update one table entry when its level is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl_valid[l] <= 1'b0;
                lvl_src[l]   <= '0;
            end else if (wr_en && (wr_lvl == LVL_W'(l))) begin
                lvl_valid[l] <= wr_valid;
                lvl_src[l]   <= wr_src;
            end
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
// intc_arbiter: combinational scan of the priority table. The lowest-index
// valid entry whose source is a candidate wins. Candidates are computed by
// the caller (pending, enabled and steered to the normal request).
module intc_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 32,
    parameter int SRC_W   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            cand,
    input  logic [NUM_LVL-1:0]            lvl_valid,
    input  logic [NUM_LVL-1:0][SRC_W-1:0] lvl_src,
    output logic                          win_valid,
    output logic [SRC_W-1:0]              win_src
);
    // Walk from the least urgent entry down so that the lowest index is kept.
    always_comb begin
        win_valid = 1'b0;
        win_src   = '0;
        for (int l = NUM_LVL - 1; l >= 0; l--) begin
            if (lvl_valid[l] && cand[lvl_src[l]]) begin
                win_valid = 1'b1;
                win_src   = lvl_src[l];
            end
        end
    end

    // R8
    win_is_candidate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> cand[win_src]);

    // R8
    no_cand_no_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |-> !win_valid);
endmodule

// File: rtl/prio_intc.sv
// prio_intc: memory-mapped prioritized interrupt controller.
// Assumes level-sensitive sources that are cleared at the peripheral, a
// single-cycle write strobe, and a reader that samples bus_rdata one cycle
// after presenting the address.
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_LVL = 32,
    parameter int ADDR_W  = 8,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int LVL_W  = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o
);
    logic [NUM_SRC-1:0]            raw;
    logic [NUM_SRC-1:0]            enable_q;
    logic [NUM_SRC-1:0]            steer_q;
    logic                          ctrl_q;
    logic [NUM_SRC-1:0]            irq_pend;
    logic [NUM_SRC-1:0]            fiq_pend;
    logic [NUM_LVL-1:0]            lvl_valid;
    logic [NUM_LVL-1:0][SRC_W-1:0] lvl_src;
    logic                          win_valid;
    logic [SRC_W-1:0]              win_src;
    logic [WORD_W-1:0]             word;
    logic [WORD_W-1:0]             tbl_off;
    logic                          aligned;
    logic                          tbl_hit;
    logic [LVL_W-1:0]              tbl_lvl;
    logic [DATA_W-1:0]             rd_next;
    logic [DATA_W-1:0]             winner_word;

    intc_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(src_i[NUM_SRC-1:0]), .sync_o(raw)
    );

    // Address decode: word index, alignment and table-range detection.
    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign tbl_off = word - WORD_W'(W_TABLE0);
    assign tbl_hit = aligned && (word >= WORD_W'(W_TABLE0))
                   && (tbl_off < WORD_W'(NUM_LVL));
    assign tbl_lvl = tbl_off[LVL_W-1:0];

    // Configuration registers: enable, steering and wake control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            steer_q  <= '0;
            ctrl_q   <= 1'b0;
        end else if (bus_we && aligned) begin
            if (word == WORD_W'(W_ENABLE)) enable_q <= bus_wdata[NUM_SRC-1:0];
            if (word == WORD_W'(W_STEER))  steer_q  <= bus_wdata[NUM_SRC-1:0];
            if (word == WORD_W'(W_CTRL))   ctrl_q   <= bus_wdata[0];
        end
    end

    intc_prio_bank #(.NUM_LVL(NUM_LVL), .SRC_W(SRC_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_we && tbl_hit), .wr_lvl(tbl_lvl),
        .wr_valid(bus_wdata[31]), .wr_src(bus_wdata[SRC_W-1:0]),
        .lvl_valid(lvl_valid), .lvl_src(lvl_src)
    );

    // Pending vectors split by steering.
    assign irq_pend = raw & enable_q & ~steer_q;
    assign fiq_pend = raw & enable_q & steer_q;

    intc_arbiter #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .SRC_W(SRC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .cand(irq_pend),
        .lvl_valid(lvl_valid), .lvl_src(lvl_src),
        .win_valid(win_valid), .win_src(win_src)
    );

    // Request and wake outputs.
    assign irq_o  = |irq_pend;
    assign fiq_o  = |fiq_pend;
    assign wake_o = ctrl_q ? |(raw & enable_q) : |raw;

    assign winner_word = win_valid ? {1'b1, 15'(win_src), 16'h0000} : '0;

    // Read multiplexer for the addressed word.
    always_comb begin
        rd_next = '0;
        if (tbl_hit) begin
            rd_next = {lvl_valid[tbl_lvl], {(DATA_W-1-SRC_W){1'b0}}, lvl_src[tbl_lvl]};
        end else if (aligned) begin
            case (word)
                WORD_W'(W_IRQPEND): rd_next = DATA_W'(irq_pend);
                WORD_W'(W_ENABLE):  rd_next = DATA_W'(enable_q);
                WORD_W'(W_STEER):   rd_next = DATA_W'(steer_q);
                WORD_W'(W_FIQPEND): rd_next = DATA_W'(fiq_pend);
                WORD_W'(W_RAW):     rd_next = DATA_W'(raw);
                WORD_W'(W_CTRL):    rd_next = DATA_W'(ctrl_q);
                WORD_W'(W_WINNER):  rd_next = winner_word;
                default:            rd_next = '0;
            endcase
        end
    end

    // Register the read data so it appears one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    // R2
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> (!irq_o && !fiq_o));

    // R9
    winner_implies_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> irq_o);

    // R10
    gated_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q && wake_o) |-> ((raw & enable_q) != '0));

    // R4
    irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (raw != '0));
endmodule

// File: tb/prio_intc_test.sv
// Self-checking bench for prio_intc: one-hot sweeps and pseudo-random mixes
// against a model kept in the bench.
module prio_intc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_en = '0, m_st = '0, m_src = '0;
    logic        m_ctrl = 1'b0;
    logic        m_pv [32];
    logic [4:0]  m_ps [32];
    logic [31:0] seed = 32'h1234_5678;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
    );

    always #10 clk = ~clk; // 50 MHz

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed ^ (seed >> 13);
    endfunction

    function automatic logic [31:0] exp_irqp();
        return m_src & m_en & ~m_st;
    endfunction

    function automatic logic [31:0] exp_fiqp();
        return m_src & m_en & m_st;
    endfunction

    function automatic logic exp_wake();
        return m_ctrl ? |(m_src & m_en) : |m_src;
    endfunction

    function automatic logic [31:0] exp_win();
        logic [31:0] c = exp_irqp();
        for (int l = 0; l < 32; l++)
            if (m_pv[l] && c[m_ps[l]]) return {1'b1, 10'b0, m_ps[l], 16'h0000};
        return 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_i = v; m_src = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_en(input logic [31:0] v);
        bus_wr(8'h04, v); m_en = v;
    endtask

    task automatic set_st(input logic [31:0] v);
        bus_wr(8'h08, v); m_st = v;
    endtask

    task automatic set_ctrl(input logic v);
        bus_wr(8'h14, {31'h7fff_ffff, v}); m_ctrl = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        for (int l = 0; l < 32; l++) begin m_pv[l] = 1'b0; m_ps[l] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R2, R3, R7, R9, R10.
        bus_rd(8'h04, d); chk("R2 enable reset", d, 32'h0);
        bus_rd(8'h08, d); chk("R3 steer reset", d, 32'h0);
        bus_rd(8'h14, d); chk("R10 ctrl reset", d, 32'h0);
        bus_rd(8'h1C, d); chk("R7 table0 reset", d, 32'h0);
        bus_rd(8'h98, d); chk("R7 table31 reset", d, 32'h0);
        bus_rd(8'h18, d); chk("R9 winner reset", d, 32'h0);
        set_src(32'hFFFF_FFFF);
        chk("R2 blocked irq", {31'b0, irq_o}, 32'h0);
        chk("R2 blocked fiq", {31'b0, fiq_o}, 32'h0);
        chk("R10 wake any raw", {31'b0, wake_o}, 32'h1);
        bus_rd(8'h10, d); chk("R6 raw lines", d, 32'hFFFF_FFFF);
        bus_rd(8'h11, d); chk("R1 misaligned read", d, 32'h0);

        // R6 latency: outputs move on the second edge, not the first.
        set_src(32'h0);
        set_en(32'hFFFF_FFFF);
        @(negedge clk);
        src_i = 32'h0000_0020; m_src = 32'h0000_0020;
        @(negedge clk);
        chk("R6 one edge irq unchanged", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R6 two edges irq", {31'b0, irq_o}, 32'h1);

        // R4/R5 one-hot sweep with mixed enable and steering.
        set_en(32'h0F0F_33CC);
        set_st(32'h5A5A_A5A5);
        bus_rd(8'h04, d); chk("R1 enable readback", d, 32'h0F0F_33CC);
        bus_rd(8'h08, d); chk("R3 steer readback", d, 32'h5A5A_A5A5);
        for (int i = 0; i < 32; i++) begin
            set_src(32'h1 << i);
            chk("R4 irq_o sweep", {31'b0, irq_o}, {31'b0, |exp_irqp()});
            chk("R5 fiq_o sweep", {31'b0, fiq_o}, {31'b0, |exp_fiqp()});
            bus_rd(8'h00, d); chk("R4 normal-pending sweep", d, exp_irqp());
            bus_rd(8'h0C, d); chk("R5 fast-pending sweep", d, exp_fiqp());
            bus_rd(8'h10, d); chk("R6 raw sweep", d, m_src);
        end

        // R4/R5/R10 pseudo-random mixes, empty table so winner stays 0.
        for (int k = 0; k < 16; k++) begin
            set_en(next_rand());
            set_st(next_rand());
            set_ctrl(k[0]);
            set_src(next_rand() & next_rand());
            chk("R4 irq_o mix", {31'b0, irq_o}, {31'b0, |exp_irqp()});
            chk("R5 fiq_o mix", {31'b0, fiq_o}, {31'b0, |exp_fiqp()});
            chk("R10 wake mix", {31'b0, wake_o}, {31'b0, exp_wake()});
            bus_rd(8'h00, d); chk("R4 normal-pending mix", d, exp_irqp());
            bus_rd(8'h0C, d); chk("R5 fast-pending mix", d, exp_fiqp());
            bus_rd(8'h18, d); chk("R8 empty table winner", d, 32'h0);
        end

        // R7: only bit 31 and bits 4:0 are stored.
        bus_wr(8'h30, 32'h7FFF_FFF3);
        bus_rd(8'h30, d); chk("R7 unused bits dropped", d, 32'h0000_0013);
        bus_wr(8'h30, 32'hFFFF_FFE9);
        bus_rd(8'h30, d); chk("R7 valid entry readback", d, 32'h8000_0009);
        bus_rd(8'h14, d); chk("R10 ctrl reads bit0", d, {31'b0, m_ctrl});

        // Program the table: entry l names (7l+3) mod 32, invalid when l mod 5 == 4.
        for (int l = 0; l < 32; l++) begin
            m_pv[l] = (l % 5) != 4;
            m_ps[l] = 5'((l * 7 + 3) % 32);
            bus_wr(8'h1C + 8'(4 * l), {m_pv[l], 26'b0, m_ps[l]});
        end
        set_en(32'hFFFF_FFFF);
        set_st(32'h0000_00F0);
        for (int i = 0; i < 32; i++) begin
            set_src(32'h1 << i);
            bus_rd(8'h18, d); chk("R9 winner one-hot", d, exp_win());
        end
        // Source 31 is named only by invalid entry 4.
        set_src(32'h8000_0000);
        chk("R8 invalid entry irq_o", {31'b0, irq_o}, 32'h1);
        bus_rd(8'h18, d); chk("R8 invalid entry never wins", d, 32'h0);
        set_src(32'hFFFF_FFFF);
        bus_rd(8'h18, d); chk("R8 all pending entry0 wins", d, 32'h8003_0000);
        // Source 3 steered to fast request: next valid entry wins.
        set_st(32'h0000_00F8);
        bus_rd(8'h18, d); chk("R8 steered source skipped", d, exp_win());
        for (int k = 0; k < 16; k++) begin
            set_en(next_rand());
            set_st(next_rand() & next_rand());
            set_src(next_rand());
            bus_rd(8'h18, d); chk("R8 winner mix", d, exp_win());
        end

        // R11: writes to read-only offsets change nothing.
        set_en(32'h00FF_00FF);
        set_st(32'h0F00_0F00);
        set_src(32'h3333_CCCC);
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_wr(8'h0C, 32'hFFFF_FFFF);
        bus_wr(8'h10, 32'h0);
        bus_wr(8'h18, 32'h0);
        bus_wr(8'h05, 32'h0);
        bus_rd(8'h00, d); chk("R11 normal-pending kept", d, exp_irqp());
        bus_rd(8'h0C, d); chk("R11 fast-pending kept", d, exp_fiqp());
        bus_rd(8'h10, d); chk("R11 raw kept", d, m_src);
        bus_rd(8'h18, d); chk("R11 winner kept", d, exp_win());
        bus_rd(8'h04, d); chk("R1 misaligned write ignored", d, 32'h00FF_00FF);

        // R10: wake gating.
        set_ctrl(1'b1);
        set_en(32'h0);
        set_src(32'h0000_1000);
        chk("R10 gated wake blocked", {31'b0, wake_o}, 32'h0);
        set_en(32'h0000_1000);
        chk("R10 gated wake enabled", {31'b0, wake_o}, 32'h1);
        set_ctrl(1'b0);
        set_en(32'h0);
        chk("R10 ungated wake", {31'b0, wake_o}, 32'h1);
        set_src(32'h0);
        chk("R10 no lines no wake", {31'b0, wake_o}, 32'h0);

        finish_run();
    end
endmodule